// File: doc/BRIEF.md
# Halfword Multiply-Accumulate Unit

This block is a pipelined multiply-accumulate datapath for 16-bit operands. Each operation picks one 16-bit halfword from each of two 32-bit source words. It treats the pair as signed or unsigned and multiplies them. The product is then returned as is, added to a 32-bit accumulator value, or subtracted from it. The 32-bit result either wraps modulo 2^32 or saturates at the limits of the chosen number format.

A new operation can be issued on every clock cycle, whatever its kind. Each result appears two cycles after its operation is issued, and a valid flag travels with it. The caller supplies the accumulator value with each operation, so this block holds no architectural state beyond its pipeline. Reset is asserted asynchronously and released synchronously inside the block through a two-stage synchronizer.

Top module: `mac16_unit`

## Requirements
- R1: `pick_a_hi` selects bits [31:16] of `src_a` when 1 and bits [15:0] when 0. `pick_b_hi` does the same for `src_b`, independently of `pick_a_hi`.
- R2: With `is_signed`=1 both selected halfwords are two's-complement values. With `is_signed`=0 both are unsigned, and the accumulator value is read in the same format.
- R3: With `do_acc`=0 the accumulator is treated as zero, so the result is the product: its low 32 bits when not saturating.
- R4: With `do_acc`=1 and `do_neg`=0, the result is `acc_in` plus the product, taken modulo 2^32 when `do_sat`=0.
- R5: With `do_neg`=1 the product is subtracted instead of added, from `acc_in` or from zero when `do_acc`=0.
- R6: With `do_sat`=1 and `is_signed`=1, an exact result above 2^31-1 gives 0x7FFFFFFF and an exact result below -2^31 gives 0x80000000.
- R7: With `do_sat`=1 and `is_signed`=0, an exact result above 2^32-1 gives 0xFFFFFFFF and an exact result below 0 gives 0x00000000.
- R8: An operation issued with `in_valid`=1 at rising edge k has its result on `result` with `out_valid`=1 after edge k+2. Operations issued on consecutive cycles each produce their own result on consecutive cycles.
- R9: After reset `out_valid` is 0 and `result` is 0. In any cycle where `out_valid` is 0, `result` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Issue an operation this cycle |
| src_a | input | 32 | Source word holding operand A |
| src_b | input | 32 | Source word holding operand B |
| acc_in | input | 32 | Accumulator value |
| pick_a_hi | input | 1 | 1: upper halfword of src_a, 0: lower |
| pick_b_hi | input | 1 | 1: upper halfword of src_b, 0: lower |
| is_signed | input | 1 | 1: signed operands and accumulator |
| do_acc | input | 1 | 1: combine with acc_in, 0: plain multiply |
| do_neg | input | 1 | 1: subtract the product |
| do_sat | input | 1 | 1: saturate, 0: wrap |
| out_valid | output | 1 | Result valid |
| result | output | 32 | 32-bit result |

## Verification
Random operands over all 64 combinations of the control bits, issued back to back and with idle gaps, cover the product, sum and difference paths. Directed halfword-select patterns with distinct values in each half tell apart which half of each source feeds the multiplier. The value 0xFFFF run as signed and then as unsigned separates the two operand formats. Accumulators placed next to each clamp limit, in both directions, show whether the block clamps or wraps on overflow and underflow, and idle cycles show that the last result is held.

// File: rtl/mac16_pkg.sv
package mac16_pkg;
  parameter int WORD_W = 32;
  parameter int OP_W   = 16;
  localparam int EXT_W  = OP_W + 1;
  localparam int PROD_W = 2 * EXT_W;
  localparam int SUM_W  = WORD_W + 3;
  localparam int N_OPND = 2;

  typedef struct packed {
    logic sgn;
    logic neg;
    logic sat;
  } mac_ctl_t;
endpackage

// File: rtl/mac16_operand_pick.sv
module mac16_operand_pick
  import mac16_pkg::*;
#(
  parameter int SRC_W = WORD_W,
  parameter int HW_W  = OP_W
) (
  input  logic [SRC_W-1:0]      src,
  input  logic                  pick_hi,
  input  logic                  sgn,
  output logic signed [HW_W:0]  opnd
);
  logic [HW_W-1:0] half;

  always_comb begin
    half = pick_hi ? src[SRC_W-1 -: HW_W] : src[HW_W-1:0];
    opnd = {sgn & half[HW_W-1], half};
  end
endmodule

// File: rtl/mac16_mul_stage.sv
module mac16_mul_stage
  import mac16_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [EXT_W-1:0]  opnd_a,
  input  logic signed [EXT_W-1:0]  opnd_b,
  input  logic [WORD_W-1:0]        acc_in,
  input  logic                     do_acc,
  input  mac_ctl_t                 ctl_in,
  output logic                     s1_valid,
  output logic signed [PROD_W-1:0] s1_prod,
  output logic signed [SUM_W-1:0]  s1_acc,
  output mac_ctl_t                 s1_ctl
);
  logic signed [PROD_W-1:0] prod_nxt;
  logic signed [SUM_W-1:0]  acc_nxt;
  logic                     load_en;

  always_comb begin
    load_en  = in_valid;
    prod_nxt = opnd_a * opnd_b;
    if (!do_acc)
      acc_nxt = '0;
    else if (ctl_in.sgn)
      acc_nxt = {{(SUM_W-WORD_W){acc_in[WORD_W-1]}}, acc_in};
    else
      acc_nxt = {{(SUM_W-WORD_W){1'b0}}, acc_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_valid <= 1'b0;
    else        s1_valid <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_prod <= '0;
      s1_acc  <= '0;
      s1_ctl  <= '0;
    end else if (load_en) begin
      s1_prod <= prod_nxt;
      s1_acc  <= acc_nxt;
      s1_ctl  <= ctl_in;
    end
  end

  // R8: every issued operation enters the second stage on the next edge
  assert_stage1_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_valid);
  // R3: a plain multiply carries a zero accumulator forward
  assert_plain_zero_acc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !do_acc) |=> (s1_acc == '0));
endmodule

// File: rtl/mac16_acc_stage.sv
module mac16_acc_stage
  import mac16_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s1_valid,
  input  logic signed [PROD_W-1:0] s1_prod,
  input  logic signed [SUM_W-1:0]  s1_acc,
  input  mac_ctl_t                 s1_ctl,
  output logic                     out_valid,
  output logic [WORD_W-1:0]        result
);
  localparam logic signed [SUM_W-1:0] S_MAX =
    {{(SUM_W-WORD_W+1){1'b0}}, {(WORD_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] S_MIN =
    {{(SUM_W-WORD_W+1){1'b1}}, {(WORD_W-1){1'b0}}};
  localparam logic signed [SUM_W-1:0] U_MAX =
    {{(SUM_W-WORD_W){1'b0}}, {WORD_W{1'b1}}};
  localparam logic [WORD_W-1:0] CLAMP_SPOS = {1'b0, {(WORD_W-1){1'b1}}};
  localparam logic [WORD_W-1:0] CLAMP_SNEG = {1'b1, {(WORD_W-1){1'b0}}};
  localparam logic [WORD_W-1:0] CLAMP_UMAX = {WORD_W{1'b1}};

  logic signed [SUM_W-1:0] prod_ext;
  logic signed [SUM_W-1:0] sum;
  logic                    over_hi;
  logic                    over_lo;
  logic [WORD_W-1:0]       result_nxt;
  logic                    load_en;

  always_comb begin
    load_en  = s1_valid;
    prod_ext = {{(SUM_W-PROD_W){s1_prod[PROD_W-1]}}, s1_prod};
    sum      = s1_ctl.neg ? (s1_acc - prod_ext) : (s1_acc + prod_ext);
    if (s1_ctl.sgn) begin
      over_hi = (sum > S_MAX);
      over_lo = (sum < S_MIN);
    end else begin
      over_hi = (sum > U_MAX);
      over_lo = sum[SUM_W-1];
    end
    if (s1_ctl.sat && over_hi)
      result_nxt = s1_ctl.sgn ? CLAMP_SPOS : CLAMP_UMAX;
    else if (s1_ctl.sat && over_lo)
      result_nxt = s1_ctl.sgn ? CLAMP_SNEG : '0;
    else
      result_nxt = sum[WORD_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= s1_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       result <= '0;
    else if (load_en) result <= result_nxt;
  end

  // R8: the output flag follows the second stage by exactly one edge
  assert_out_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_valid);
  assert_out_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> !out_valid);
  // R9: no valid operation, no change on the result
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> $stable(result));
  // R6: saturating sum of two non-negative signed terms never turns negative
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_ctl.sat && s1_ctl.sgn && !s1_ctl.neg &&
     !s1_prod[PROD_W-1] && !s1_acc[WORD_W-1]) |=> !result[WORD_W-1]);
  // R7: saturating unsigned addition never lands below the accumulator
  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_ctl.sat && !s1_ctl.sgn && !s1_ctl.neg) |=>
    (result >= $past(s1_acc[WORD_W-1:0])));
endmodule

// File: rtl/mac16_unit.sv
module mac16_unit
  import mac16_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       src_a,
  input  logic [31:0]       src_b,
  input  logic [31:0]       acc_in,
  input  logic              pick_a_hi,
  input  logic              pick_b_hi,
  input  logic              is_signed,
  input  logic              do_acc,
  input  logic              do_neg,
  input  logic              do_sat,
  output logic              out_valid,
  output logic [31:0]       result
);
  logic [1:0] rst_sync;
  logic       rst_ok_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ok_n = rst_sync[1];

  logic [N_OPND-1:0][WORD_W-1:0]       srcs;
  logic [N_OPND-1:0]                   picks;
  logic signed [EXT_W-1:0]             opnds [N_OPND];
  mac_ctl_t                            ctl_in;

  assign srcs   = {src_b, src_a};
  assign picks  = {pick_b_hi, pick_a_hi};
  assign ctl_in = '{sgn: is_signed, neg: do_neg, sat: do_sat};

  for (genvar i = 0; i < N_OPND; i++) begin : g_pick
    mac16_operand_pick #(.SRC_W(WORD_W), .HW_W(OP_W)) u_pick (
      .src     (srcs[i]),
      .pick_hi (picks[i]),
      .sgn     (is_signed),
      .opnd    (opnds[i])
    );
  end

  logic                     s1_valid;
  logic signed [PROD_W-1:0] s1_prod;
  logic signed [SUM_W-1:0]  s1_acc;
  mac_ctl_t                 s1_ctl;

  mac16_mul_stage u_mul (
    .clk      (clk),
    .rst_n    (rst_ok_n),
    .in_valid (in_valid),
    .opnd_a   (opnds[0]),
    .opnd_b   (opnds[1]),
    .acc_in   (acc_in),
    .do_acc   (do_acc),
    .ctl_in   (ctl_in),
    .s1_valid (s1_valid),
    .s1_prod  (s1_prod),
    .s1_acc   (s1_acc),
    .s1_ctl   (s1_ctl)
  );

  mac16_acc_stage u_acc (
    .clk       (clk),
    .rst_n     (rst_ok_n),
    .s1_valid  (s1_valid),
    .s1_prod   (s1_prod),
    .s1_acc    (s1_acc),
    .s1_ctl    (s1_ctl),
    .out_valid (out_valid),
    .result    (result)
  );
endmodule

// File: tb/tb_mac16_unit.sv
module tb_mac16_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] src_a = '0, src_b = '0, acc_in = '0;
  logic        pick_a_hi = 1'b0, pick_b_hi = 1'b0;
  logic        is_signed = 1'b0, do_acc = 1'b0, do_neg = 1'b0, do_sat = 1'b0;
  logic        out_valid;
  logic [31:0] result;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  mac16_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
    .pick_a_hi(pick_a_hi), .pick_b_hi(pick_b_hi),
    .is_signed(is_signed), .do_acc(do_acc), .do_neg(do_neg), .do_sat(do_sat),
    .out_valid(out_valid), .result(result)
  );

  // expectation pipeline: index 0 newest, index 1 due at this sample
  bit          p_v [2];
  logic [31:0] p_e [2];
  string       p_t [2];
  logic [31:0] last_res = '0;

  function automatic logic [31:0] model(input logic [31:0] a, b, acc,
      input bit ahi, bhi, sgn, accum, neg, sat, output bit clamped);
    logic [15:0] ha, hb;
    longint x, y, c, s;
    ha = ahi ? a[31:16] : a[15:0];
    hb = bhi ? b[31:16] : b[15:0];
    x = sgn ? longint'($signed(ha)) : longint'(ha);
    y = sgn ? longint'($signed(hb)) : longint'(hb);
    c = !accum ? 0 : (sgn ? longint'($signed(acc)) : longint'(acc));
    s = neg ? c - x * y : c + x * y;
    clamped = 1'b0;
    if (sat) begin
      if (sgn && s > 64'sd2147483647)       begin s = 64'sh7FFFFFFF; clamped = 1; end
      else if (sgn && s < -64'sd2147483648) begin s = 64'sh80000000; clamped = 1; end
      else if (!sgn && s > 64'sd4294967295) begin s = 64'shFFFFFFFF; clamped = 1; end
      else if (!sgn && s < 0)               begin s = 0;             clamped = 1; end
    end
    return s[31:0];
  endfunction

  function automatic void check(input string tag, input logic [31:0] act, exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endfunction

  // one cycle: check the due output, then drive the next input (at negedge)
  task automatic step(input bit v, input logic [31:0] a, b, acc,
      input bit ahi, bhi, sgn, accum, neg, sat, input string tag);
    logic [31:0] e;
    bit cl;
    string t;
    @(negedge clk);
    check("R8 out_valid", {31'd0, out_valid}, {31'd0, p_v[1]});
    if (p_v[1]) begin
      check(p_t[1], result, p_e[1]);
      last_res = p_e[1];
    end else begin
      check("R9 hold", result, last_res);
    end
    e = model(a, b, acc, ahi, bhi, sgn, accum, neg, sat, cl);
    if (tag != "") t = tag;
    else if (cl) t = sgn ? "R6 signed clamp" : "R7 unsigned clamp";
    else if (neg) t = "R5 subtract";
    else if (accum) t = "R4 accumulate";
    else t = "R3 multiply";
    p_v[1] = p_v[0]; p_e[1] = p_e[0]; p_t[1] = p_t[0];
    p_v[0] = v;      p_e[0] = e;      p_t[0] = t;
    in_valid = v; src_a = a; src_b = b; acc_in = acc;
    pick_a_hi = ahi; pick_b_hi = bhi; is_signed = sgn;
    do_acc = accum; do_neg = neg; do_sat = sat;
  endtask

  task automatic op(input logic [31:0] a, b, acc,
      input bit ahi, bhi, sgn, accum, neg, sat, input string tag);
    step(1'b1, a, b, acc, ahi, bhi, sgn, accum, neg, sat, tag);
  endtask

  task automatic idle();
    step(1'b0, '0, '0, '0, 0, 0, 0, 0, 0, 0, "");
  endtask

  bit done = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    p_v[0] = 0; p_v[1] = 0;
    p_e[0] = '0; p_e[1] = '0;
    p_t[0] = ""; p_t[1] = "";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 reset out_valid", {31'd0, out_valid}, 32'd0);
    check("R9 reset result", result, 32'd0);

    // R1: halfword selection, unsigned plain multiply
    op(32'h0003_0005, 32'h0007_0002, 0, 0, 0, 0, 0, 0, 0, "R1 lo/lo");
    op(32'h0003_0005, 32'h0007_0002, 0, 1, 0, 0, 0, 0, 0, "R1 hi/lo");
    op(32'h0003_0005, 32'h0007_0002, 0, 0, 1, 0, 0, 0, 0, "R1 lo/hi");
    op(32'h0003_0005, 32'h0007_0002, 0, 1, 1, 0, 0, 0, 0, "R1 hi/hi");
    // R2: same bits, signed versus unsigned
    op(32'h0000_FFFF, 32'h0000_0002, 0, 0, 0, 1, 0, 0, 0, "R2 signed");
    op(32'h0000_FFFF, 32'h0000_0002, 0, 0, 0, 0, 0, 0, 0, "R2 unsigned");
    op(32'hFFFF_0000, 32'h0002_0000, 32'hFFFF_FFFF, 1, 1, 1, 1, 0, 0, "R2 signed acc");
    // R3: largest signed product
    op(32'h0000_8000, 32'h0000_8000, 32'h1234_5678, 0, 0, 1, 0, 0, 0, "R3 -32768^2");
    op(32'h0000_FFFF, 32'h0000_FFFF, 0, 0, 0, 0, 0, 0, 0, "R3 max unsigned");
    // R5: negate without accumulator
    op(32'h0000_0003, 32'h0000_0004, 0, 0, 0, 1, 0, 1, 0, "R5 plain negate");
    // R4/R6: signed overflow wraps or clamps
    op(32'h0000_7FFF, 32'h0000_7FFF, 32'h7FFF_FFF0, 0, 0, 1, 1, 0, 0, "R4 signed wrap");
    op(32'h0000_7FFF, 32'h0000_7FFF, 32'h7FFF_FFF0, 0, 0, 1, 1, 0, 1, "R6 positive clamp");
    op(32'h0000_0001, 32'h0000_0001, 32'h8000_0000, 0, 0, 1, 1, 1, 1, "R6 negative clamp");
    op(32'h0000_0001, 32'h0000_0001, 32'h8000_0000, 0, 0, 1, 1, 1, 0, "R5 signed wrap");
    // R7: unsigned overflow and underflow
    op(32'h0000_FFFF, 32'h0000_FFFF, 32'hFFFF_FFF0, 0, 0, 0, 1, 0, 1, "R7 unsigned max");
    op(32'h0000_0003, 32'h0000_0002, 32'h0000_0005, 0, 0, 0, 1, 1, 1, "R7 unsigned floor");
    op(32'h0000_0003, 32'h0000_0002, 32'h0000_0005, 0, 0, 0, 1, 1, 0, "R5 unsigned wrap");
    op(32'h0000_0003, 32'h0000_0002, 32'h0000_0005, 0, 0, 0, 0, 1, 1, "R7 plain negate floor");
    idle(); idle(); idle();

    // R8: random mix, back to back with occasional gaps
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[2:0] == 3'd0) idle();
      else begin
        logic [31:0] acc;
        acc = $urandom;
        if (r[9:8] == 2'd0) acc = r[10] ? 32'h7FFF_FF00 : 32'h8000_00FF;
        if (r[9:8] == 2'd1) acc = r[10] ? 32'hFFFF_FF00 : 32'h0000_00FF;
        op($urandom, $urandom, acc, r[3], r[4], r[5], r[6], r[7], r[11], "");
      end
    end
    idle(); idle(); idle();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule